// File: doc/BRIEF.md
# Attention Interrupt Mask Logic

This block owns the two-bit interrupt mask register of a block-transfer style host/BMC mailbox. It decides when the host interrupt line is raised and dropped. The state is an enable bit and a sticky pending bit. The level interrupt output follows the pending bit. Pending is set only on specific events: the host enabling the interrupt while an attention flag is already up, a response arriving that raises BMC-to-host attention, or the management side newly raising SMS attention. It is cleared by a host write-one-to-clear, by disabling, by the management side dropping SMS attention, or by a cold reset.

The attention flags themselves live in a neighbouring control register and reach this block as levels. Attention-set events from the response path and from the management side arrive as single-cycle strobes. A global interrupt-enable input and an "interrupt line present" configuration input gate the event-driven paths. When several things happen in one cycle, they are applied in a fixed order: mask write first, then the response event, then the SMS request.

Top module: `attn_irq_mask`

## Requirements
- R1: The mask readback carries enable in bit 0 and pending in bit 1, and bits 7:2 always read 0. `irq_out` equals the pending bit.
- R2: A mask write with bit 0 = 1 while enable is 0 sets enable. In the same write, it sets pending if `b2h_attn` or `sms_attn` is 1. With both flags at 0, pending stays 0.
- R3: A mask write with bit 0 = 0 while enable is 1 clears both enable and pending.
- R4: A mask write with bit 1 = 1 clears pending. A write with bit 1 = 0 and bit 0 equal to the current enable changes nothing.
- R5: A response strobe sets pending only when `irq_line_present`, `irq_glb_en` and enable are all 1 and pending is 0.
- R6: An SMS request to raise the flag (`sms_req_val` = 1 while `sms_attn` = 0) sets pending only if all of these hold: `sms_req_irq` = 1; BMC-to-host attention is clear (it counts as set when the response strobe is active in the same cycle); the line is present; global enable and enable are 1. A request equal to the current `sms_attn` value has no effect.
- R7: An SMS request to drop the flag (`sms_req_val` = 0 while `sms_attn` = 1) clears pending when BMC-to-host attention is clear. It leaves pending alone when that attention is set.
- R8: `cold_rst` clears enable and pending, overriding every other event in the same cycle.
- R9: Asserting `rst_n` low clears enable and pending at once, without a clock.
- R10: Events in one cycle are applied in order: mask write (enable change, then write-one-to-clear), then the response strobe, then the SMS request. Each step sees the state the previous step left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Host write strobe for the mask register |
| mask_wdata | input | 8 | Host write data (bit 0 enable, bit 1 write-one-to-clear pending) |
| b2h_attn | input | 1 | Current BMC-to-host attention flag |
| sms_attn | input | 1 | Current SMS attention flag |
| rsp_attn_set | input | 1 | Strobe: response path raises BMC-to-host attention |
| sms_req_valid | input | 1 | Strobe: management side requests an SMS attention value |
| sms_req_val | input | 1 | Requested SMS attention value |
| sms_req_irq | input | 1 | The SMS request asks for an interrupt |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_line_present | input | 1 | An interrupt line is wired to this block |
| cold_rst | input | 1 | Synchronous cold-reset strobe |
| mask_rdata | output | 8 | Mask register readback |
| irq_out | output | 1 | Level host interrupt |

## Verification
On every cycle, the assertions check the following:
- disabling and cold reset leave the interrupt low on the next cycle;
- a plain write-one-to-clear with no other event drops pending;
- a rising interrupt always traces back to enable being set or being written;
- a rising interrupt without a mask write traces back to the line-present and global-enable gates.

Other behaviours can only be shown by the bench's scenarios:
- whether an event sets pending at all;
- that no-op SMS requests are ignored;
- that a dropped SMS flag clears pending only when BMC-to-host attention is clear;
- the same-cycle ordering.

The bench covers these with directed cases and a sweep over every input combination from each reachable state.

// File: rtl/attn_irq_pkg.sv
package attn_irq_pkg;
  localparam int unsigned MASK_W_DEF   = 8;
  localparam int unsigned EN_POS_DEF   = 0;
  localparam int unsigned PEND_POS_DEF = 1;

  typedef struct packed {
    logic en;
    logic pend;
  } irq_state_t;
endpackage

// File: rtl/attn_mask_port_stage.sv
// Applies a host write to the mask register: enable edge first, then W1C.
module attn_mask_port_stage
  import attn_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = MASK_W_DEF,
  parameter int unsigned EN_BIT   = EN_POS_DEF,
  parameter int unsigned PEND_BIT = PEND_POS_DEF
) (
  input  irq_state_t        cur,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              any_attn,
  output irq_state_t        nxt
);
  logic en_req;
  logic clr_req;

  assign en_req  = wdata[EN_BIT];
  assign clr_req = wdata[PEND_BIT];

  always_comb begin
    nxt = cur;
    if (wr) begin
      if (en_req != cur.en) begin
        if (en_req) begin
          nxt.en = 1'b1;
          if (any_attn) nxt.pend = 1'b1;
        end else begin
          nxt.en   = 1'b0;
          nxt.pend = 1'b0;
        end
      end
      if (clr_req && nxt.pend) nxt.pend = 1'b0;
    end
  end
endmodule

// File: rtl/attn_event_stage.sv
// Applies the response event, then the SMS attention request.
module attn_event_stage
  import attn_irq_pkg::*;
(
  input  irq_state_t cur,
  input  logic       rsp_set,
  input  logic       b2h_attn,
  input  logic       sms_attn,
  input  logic       sms_req_valid,
  input  logic       sms_req_val,
  input  logic       sms_req_irq,
  input  logic       glb_en,
  input  logic       line_present,
  output irq_state_t nxt
);
  logic       deliver;
  logic       b2h_eff;
  logic       sms_change;
  irq_state_t after_rsp;

  assign deliver    = line_present & glb_en;
  assign b2h_eff    = b2h_attn | rsp_set;
  assign sms_change = sms_req_valid & (sms_req_val != sms_attn);

  always_comb begin
    after_rsp = cur;
    if (rsp_set && deliver && cur.en && !cur.pend) after_rsp.pend = 1'b1;
  end

  always_comb begin
    nxt = after_rsp;
    if (sms_change) begin
      if (sms_req_val) begin
        if (sms_req_irq && deliver && !b2h_eff && after_rsp.en) nxt.pend = 1'b1;
      end else begin
        if (!b2h_eff && after_rsp.pend) nxt.pend = 1'b0;
      end
    end
  end
endmodule

// File: rtl/attn_mask_regs.sv
// State register with cold reset, written-out clock enable and readback map.
module attn_mask_regs
  import attn_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = MASK_W_DEF,
  parameter int unsigned EN_BIT   = EN_POS_DEF,
  parameter int unsigned PEND_BIT = PEND_POS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_rst,
  input  irq_state_t        nxt,
  output irq_state_t        cur,
  output logic [DATA_W-1:0] rdata
);
  irq_state_t state_q;
  irq_state_t state_d;
  logic       state_upd;

  always_comb begin
    state_d   = cold_rst ? '0 : nxt;
    state_upd = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= '0;
    else if (state_upd) state_q <= state_d;
  end

  assign cur = state_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i == EN_BIT) begin : g_en
      assign rdata[i] = state_q.en;
    end else if (i == PEND_BIT) begin : g_pend
      assign rdata[i] = state_q.pend;
    end else begin : g_zero
      assign rdata[i] = 1'b0;
    end
  end
endmodule

// File: rtl/attn_irq_mask.sv
module attn_irq_mask
  import attn_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = MASK_W_DEF,
  parameter int unsigned EN_BIT   = EN_POS_DEF,
  parameter int unsigned PEND_BIT = PEND_POS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_wdata,
  input  logic              b2h_attn,
  input  logic              sms_attn,
  input  logic              rsp_attn_set,
  input  logic              sms_req_valid,
  input  logic              sms_req_val,
  input  logic              sms_req_irq,
  input  logic              irq_glb_en,
  input  logic              irq_line_present,
  input  logic              cold_rst,
  output logic [DATA_W-1:0] mask_rdata,
  output logic              irq_out
);
  irq_state_t st_cur;
  irq_state_t st_port;
  irq_state_t st_evt;

  attn_mask_port_stage #(
    .DATA_W(DATA_W), .EN_BIT(EN_BIT), .PEND_BIT(PEND_BIT)
  ) u_port (
    .cur     (st_cur),
    .wr      (mask_wr),
    .wdata   (mask_wdata),
    .any_attn(b2h_attn | sms_attn),
    .nxt     (st_port)
  );

  attn_event_stage u_evt (
    .cur          (st_port),
    .rsp_set      (rsp_attn_set),
    .b2h_attn     (b2h_attn),
    .sms_attn     (sms_attn),
    .sms_req_valid(sms_req_valid),
    .sms_req_val  (sms_req_val),
    .sms_req_irq  (sms_req_irq),
    .glb_en       (irq_glb_en),
    .line_present (irq_line_present),
    .nxt          (st_evt)
  );

  attn_mask_regs #(
    .DATA_W(DATA_W), .EN_BIT(EN_BIT), .PEND_BIT(PEND_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cold_rst(cold_rst),
    .nxt     (st_evt),
    .cur     (st_cur),
    .rdata   (mask_rdata)
  );

  assign irq_out = st_cur.pend;
endmodule

// File: rtl/attn_irq_mask_chk.sv
module attn_irq_mask_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned EN_BIT   = 0,
  parameter int unsigned PEND_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mask_wr,
  input logic [DATA_W-1:0] mask_wdata,
  input logic              rsp_attn_set,
  input logic              sms_req_valid,
  input logic              irq_glb_en,
  input logic              irq_line_present,
  input logic              cold_rst,
  input logic [DATA_W-1:0] mask_rdata,
  input logic              irq_out
);
  a_r3_disable_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wdata[EN_BIT]) |=> (!irq_out && !mask_rdata[EN_BIT]));

  a_r4_w1c_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_wdata[PEND_BIT] && !rsp_attn_set && !sms_req_valid) |=> !irq_out);

  a_r8_cold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cold_rst |=> (!irq_out && !mask_rdata[EN_BIT]));

  a_r2_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(mask_rdata[EN_BIT] || (mask_wr && mask_wdata[EN_BIT])));

  a_r5_rise_needs_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_out) && !$past(mask_wr)) |-> $past(irq_line_present && irq_glb_en));
endmodule

bind attn_irq_mask attn_irq_mask_chk #(
  .DATA_W(DATA_W), .EN_BIT(EN_BIT), .PEND_BIT(PEND_BIT)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mask_wr         (mask_wr),
  .mask_wdata      (mask_wdata),
  .rsp_attn_set    (rsp_attn_set),
  .sms_req_valid   (sms_req_valid),
  .irq_glb_en      (irq_glb_en),
  .irq_line_present(irq_line_present),
  .cold_rst        (cold_rst),
  .mask_rdata      (mask_rdata),
  .irq_out         (irq_out)
);

// File: tb/attn_irq_mask_test.sv
`timescale 1ns/1ps
module attn_irq_mask_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mask_wr, b2h_attn, sms_attn, rsp_attn_set;
  logic       sms_req_valid, sms_req_val, sms_req_irq;
  logic       irq_glb_en, irq_line_present, cold_rst;
  logic [7:0] mask_wdata, mask_rdata;
  logic       irq_out;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  attn_irq_mask uut (.*);

  task automatic zero();
    mask_wr = 0; mask_wdata = 8'h00; b2h_attn = 0; sms_attn = 0;
    rsp_attn_set = 0; sms_req_valid = 0; sms_req_val = 0; sms_req_irq = 0;
    irq_glb_en = 0; irq_line_present = 0; cold_rst = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    total++;
    if (mask_rdata !== exp || irq_out !== exp[1]) begin
      bad++;
      $display("FAIL %s: rdata=%02h irq=%b expected rdata=%02h irq=%b",
               tag, mask_rdata, irq_out, exp, exp[1]);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    zero(); mask_wr = 1; mask_wdata = d; cyc(); zero();
  endtask

  task automatic rsp(input logic line, input logic glb);
    zero(); rsp_attn_set = 1; irq_line_present = line; irq_glb_en = glb; cyc(); zero();
  endtask

  task automatic sms(input logic cur, input logic val, input logic irq, input logic b2h);
    zero(); sms_attn = cur; sms_req_valid = 1; sms_req_val = val; sms_req_irq = irq;
    b2h_attn = b2h; irq_line_present = 1; irq_glb_en = 1; cyc(); zero();
  endtask

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    zero();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9 reset state", 8'h00);
    rst_n = 1;
    cyc();
    check("R1 idle readback", 8'h00);

    wr(8'h01);            check("R2 enable with flags clear", 8'h01);
    rsp(1, 1);            check("R5 response sets pending", 8'h03);
    wr(8'h03);            check("R4 w1c clears pending", 8'h01);
    wr(8'h01);            check("R4 unchanged write no effect", 8'h01);
    rsp(0, 1);            check("R5 no line no pending", 8'h01);
    rsp(1, 0);            check("R5 global off no pending", 8'h01);
    rsp(1, 1);            check("R5 response again", 8'h03);
    rsp(1, 1);            check("R5 already pending", 8'h03);
    wr(8'h00);            check("R3 disable clears both", 8'h00);
    rsp(1, 1);            check("R5 enable clear no pending", 8'h00);
    zero(); mask_wr = 1; mask_wdata = 8'h01; sms_attn = 1; cyc(); zero();
    check("R2 enable with sms flag", 8'h03);
    zero(); cold_rst = 1; rsp_attn_set = 1; irq_line_present = 1; irq_glb_en = 1;
    mask_wr = 1; mask_wdata = 8'h01; cyc(); zero();
    check("R8 cold reset overrides", 8'h00);
    wr(8'h01);
    sms(0, 1, 1, 0);      check("R6 sms raise sets pending", 8'h03);
    sms(1, 0, 0, 0);      check("R7 sms drop clears pending", 8'h01);
    rsp(1, 1);
    sms(1, 0, 0, 1);      check("R7 sms drop with b2h keeps", 8'h03);
    wr(8'h03);            check("R4 w1c again", 8'h01);
    sms(1, 1, 1, 0);      check("R6 same value ignored", 8'h01);
    sms(0, 1, 0, 0);      check("R6 no irq requested", 8'h01);
    sms(0, 1, 1, 1);      check("R6 b2h set blocks", 8'h01);
    rsp(1, 1);
    zero(); mask_wr = 1; mask_wdata = 8'h03; rsp_attn_set = 1;
    irq_line_present = 1; irq_glb_en = 1; cyc(); zero();
    check("R10 w1c then response re-sets", 8'h03);
    wr(8'h03);
    zero(); sms_req_valid = 1; sms_req_val = 1; sms_req_irq = 1; rsp_attn_set = 1;
    irq_line_present = 1; irq_glb_en = 1; cyc(); zero();
    check("R10 response counts as b2h for sms", 8'h03);

    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 2048; v++) begin
        logic e, p, beff;
        logic [10:0] b;
        zero(); cold_rst = 1; cyc(); zero();
        if (st > 0) begin
          mask_wr = 1; mask_wdata = 8'h01; b2h_attn = (st == 2); cyc(); zero();
        end
        e = (st > 0); p = (st == 2);
        b = v[10:0];
        mask_wr = b[0]; mask_wdata = {6'b0, b[2], b[1]}; b2h_attn = b[3];
        sms_attn = b[4]; rsp_attn_set = b[5]; sms_req_valid = b[6];
        sms_req_val = b[7]; sms_req_irq = b[8]; irq_glb_en = b[9];
        irq_line_present = b[10];
        cyc(); zero();
        if (b[0]) begin
          if (b[1] != e) begin
            if (b[1]) begin e = 1; if (b[3] | b[4]) p = 1; end
            else begin e = 0; p = 0; end
          end
          if (b[2]) p = 0;
        end
        beff = b[3] | b[5];
        if (b[5] && b[10] && b[9] && e && !p) p = 1;
        if (b[6] && (b[7] != b[4])) begin
          if (b[7]) begin
            if (b[8] && b[10] && b[9] && !beff && e) p = 1;
          end else if (!beff) p = 0;
        end
        check("R10 sweep", {6'b0, p, e});
      end
    end

    wr(8'h01); rsp(1, 1);
    #1 rst_n = 0; #1;
    check("R9 async reset clears", 8'h00);
    cyc(); rst_n = 1; cyc();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule